// File: doc/BRIEF.md
# Asynchronous Timer Register Update Staging

This block connects a processor write/read port, clocked by the system clock, to the five registers of an 8-bit timer that runs from an independent clock. The five registers are the counter, compare A, compare B, control A and control B. In asynchronous mode a processor write first lands in a system-side staging copy and raises that register's busy flag. A toggle handshake then carries the value into the timer clock domain. The flag drops only once the acknowledge has travelled back. Software polls a packed status byte to learn when a register may safely be written again.

Readback differs by register. The counter address returns the live count supplied by the timer logic. The compare and control addresses return the staging copies. A write that lands while its register is still busy is reported on a one-cycle flag. The block then re-sends the newest value, so the timer register ends up holding the last value written. In synchronous mode the two clocks are the same clock. Writes then load the timer registers on the same edge and the busy flags stay low.

Top module: `async_timer_stage`

## Requirements
- R1: Register addresses are 0 counter, 1 compare A, 2 compare B, 3 control A, 4 control B, and 5 is the read-only status byte. The status byte bits are: bit 4 counter busy, bit 3 compare A busy, bit 2 compare B busy, bit 1 control A busy, bit 0 control B busy. Bits 7:5 read zero.
- R2: In asynchronous mode, a write to addresses 0 to 4 sets that register's status bit from the next system clock cycle. No other bit changes.
- R3: A busy bit clears only after its value has reached the timer domain. From then on the timer-domain copy of that register equals the last value written to it.
- R4: In the first system cycle after an asynchronous write, the timer-domain copy still holds its previous value.
- R5: Reading addresses 1 to 4 returns the staging copy, which reflects a write from the next cycle. That copy stays unchanged until the register is written again.
- R6: Reading address 0 returns the live counter input `tmr_cnt_live`.
- R7: In asynchronous mode, `wr_while_busy` is high during a write to a register whose busy bit is set. After such a write, the timer-domain copy still settles to the newest value.
- R8: With `async_sel` low, a write loads the timer-domain copy on the write edge itself, and the status byte stays zero.
- R9: `tmr_cnt_load` pulses high for exactly one timer clock cycle each time the timer-domain counter copy is loaded.
- R10: After reset, all staging copies, timer-domain copies and busy bits are zero.
- R11: Writes to addresses 5, 6 and 7 change no staging copy, no timer-domain copy and no busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (processor side) clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| tmr_clk | input | 1 | Timer clock, asynchronous to sys_clk in asynchronous mode |
| tmr_rst_n | input | 1 | Synchronous active-low reset, timer domain |
| async_sel | input | 1 | 1: staged crossing; 0: direct writes (clocks identical) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wr_while_busy | output | 1 | Write hit a busy register this cycle |
| tmr_cnt_live | input | 8 | Running count from the timer logic |
| tmr_cnt_val | output | 8 | Timer-domain counter load value |
| tmr_cnt_load | output | 1 | One-cycle pulse when tmr_cnt_val is loaded |
| tmr_cmp_a | output | 8 | Timer-domain compare A |
| tmr_cmp_b | output | 8 | Timer-domain compare B |
| tmr_ctl_a | output | 8 | Timer-domain control A |
| tmr_ctl_b | output | 8 | Timer-domain control B |

## Verification
Two events can fall on the same system edge: a new write to a register, and the return of that register's acknowledge, which would clear its busy bit. If the write decision used the stale busy state, the newest value could be left staged and never sent. The bench provokes this by writing compare A twice, sweeping the gap between the two writes over every system cycle across one full round trip. One of those gaps places the second write on the acknowledge edge. Each case is judged by the timer-domain compare A settling to the second value once the status byte reads zero. The case is also judged by `wr_while_busy` agreeing with the busy bit seen on the write cycle.

// File: rtl/ats_pkg.sv
// Shared constants and types for the asynchronous timer register staging block.
// Assumes five staged timer registers and a 3-bit address space.
package ats_pkg;

    localparam int NREG   = 5;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CNT  = 3'd0,
        ADDR_CMPA = 3'd1,
        ADDR_CMPB = 3'd2,
        ADDR_CTLA = 3'd3,
        ADDR_CTLB = 3'd4,
        ADDR_STAT = 3'd5
    } ats_addr_e;

    // Status bit position of register index idx: counter highest, control B lowest.
    function automatic int stat_pos(input int idx);
        return NREG - 1 - idx;
    endfunction

endpackage

// File: rtl/ats_sync.sv
// Multi-flop synchronizer for a single level/toggle signal.
// Assumes the input changes at most once per several destination clocks.
module ats_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ats_xfer_chan.sv
// One staged register channel: system-side staging copy, request toggle,
// pending re-send flag, and timer-side capture with acknowledge toggle.
// Assumes: in direct mode (async_mode low) both clocks are the same clock;
// the mode changes only while the channel is idle.
module ats_xfer_chan #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          sys_clk,
    input  logic          sys_rst_n,
    input  logic          async_mode,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] stage_o,
    output logic          busy_o,
    input  logic          tmr_clk,
    input  logic          tmr_rst_n,
    output logic [DW-1:0] tmr_q_o,
    output logic          tmr_upd_o
);

    // ---------------- system domain ----------------
    logic [DW-1:0] stage_q;
    logic          req_q;
    logic          pend_q;
    logic          ack_s;
    logic          inflight;
    logic          send_now;
    logic          async_wr;

    assign inflight = req_q ^ ack_s;
    assign async_wr = async_mode && wr_hit;
    assign send_now = !inflight && (async_wr || pend_q);

    // Capture processor writes into the staging copy.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            stage_q <= '0;
        end else if (wr_hit) begin
            stage_q <= wr_data;
        end
    end

    // Launch a transfer by toggling the request when nothing is in flight.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            req_q <= 1'b0;
        end else if (send_now) begin
            req_q <= ~req_q;
        end
    end

    // Remember a write made during a transfer so the newest value is re-sent.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            pend_q <= 1'b0;
        end else if (async_wr && inflight) begin
            pend_q <= 1'b1;
        end else if (!inflight) begin
            pend_q <= 1'b0;
        end
    end

    // ---------------- timer domain ----------------
    logic          req_s;
    logic          req_d;
    logic          ack_q;
    logic          capture;
    logic          direct;
    logic [DW-1:0] tmr_q;
    logic          upd_q;

    assign capture = req_s ^ req_d;
    assign direct  = !async_mode && wr_hit;

    ats_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (tmr_clk),
        .rst_n (tmr_rst_n),
        .d     (req_q),
        .q     (req_s)
    );

    // Delay the synchronized request to detect its toggle; echo it as acknowledge.
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            req_d <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            req_d <= req_s;
            ack_q <= req_s;
        end
    end

    // Load the timer-domain copy from staging or, in direct mode, from the bus.
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            tmr_q <= '0;
        end else if (capture) begin
            tmr_q <= stage_q;
        end else if (direct) begin
            tmr_q <= wr_data;
        end
    end

    // Flag every load of the timer-domain copy for one timer cycle.
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= capture || direct;
        end
    end

    ats_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (ack_q),
        .q     (ack_s)
    );

    assign stage_o   = stage_q;
    assign busy_o    = inflight || pend_q;
    assign tmr_q_o   = tmr_q;
    assign tmr_upd_o = upd_q;

endmodule

// File: rtl/ats_rd_mux.sv
// Read multiplexer: live counter at the counter address, staging copies for
// compare/control, packed busy status byte, zero elsewhere.
module ats_rd_mux #(
    parameter int DW   = 8,
    parameter int NR   = 5,
    parameter int AW   = 3
) (
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    cnt_live,
    input  logic [NR*DW-1:0] stage_flat,
    input  logic [NR-1:0]    busy_vec,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] status;

    // Pack busy bits so that register 0 (counter) sits highest.
    genvar gi;
    generate
        for (gi = 0; gi < NR; gi++) begin : g_stat
            assign status[NR-1-gi] = busy_vec[gi];
        end
        if (DW > NR) begin : g_stat_pad
            assign status[DW-1:NR] = '0;
        end
    endgenerate

    // Select the read source by address.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ats_pkg::ADDR_CNT)) begin
            rd_data = cnt_live;
        end else if (rd_addr == AW'(ats_pkg::ADDR_STAT)) begin
            rd_data = status;
        end else begin
            for (int k = 1; k < NR; k++) begin
                if (rd_addr == AW'(k)) begin
                    rd_data = stage_flat[k*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/async_timer_stage.sv
// Top of the asynchronous timer register staging block. Decodes writes into
// one transfer channel per timer register and serves reads.
// Assumes async_sel changes only while all busy bits are zero, and that
// tmr_clk is sys_clk whenever async_sel is low.
module async_timer_stage #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      sys_clk,
    input  logic                      sys_rst_n,
    input  logic                      tmr_clk,
    input  logic                      tmr_rst_n,
    input  logic                      async_sel,
    input  logic                      wr_en,
    input  logic [ats_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [ats_pkg::ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]             rd_data,
    output logic                      wr_while_busy,
    input  logic [DW-1:0]             tmr_cnt_live,
    output logic [DW-1:0]             tmr_cnt_val,
    output logic                      tmr_cnt_load,
    output logic [DW-1:0]             tmr_cmp_a,
    output logic [DW-1:0]             tmr_cmp_b,
    output logic [DW-1:0]             tmr_ctl_a,
    output logic [DW-1:0]             tmr_ctl_b
);

    localparam int NR = ats_pkg::NREG;
    localparam int AW = ats_pkg::ADDR_W;

    logic [NR-1:0]    wr_hit;
    logic [NR-1:0]    busy_vec;
    logic [NR-1:0]    upd_vec;
    logic [NR*DW-1:0] stage_flat;
    logic [NR*DW-1:0] tmr_flat;

    genvar gi;
    generate
        for (gi = 0; gi < NR; gi++) begin : g_chan
            assign wr_hit[gi] = wr_en && (wr_addr == AW'(gi));

            ats_xfer_chan #(
                .DW          (DW),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_chan (
                .sys_clk    (sys_clk),
                .sys_rst_n  (sys_rst_n),
                .async_mode (async_sel),
                .wr_hit     (wr_hit[gi]),
                .wr_data    (wr_data),
                .stage_o    (stage_flat[gi*DW +: DW]),
                .busy_o     (busy_vec[gi]),
                .tmr_clk    (tmr_clk),
                .tmr_rst_n  (tmr_rst_n),
                .tmr_q_o    (tmr_flat[gi*DW +: DW]),
                .tmr_upd_o  (upd_vec[gi])
            );
        end
    endgenerate

    ats_rd_mux #(
        .DW (DW),
        .NR (NR),
        .AW (AW)
    ) u_rd_mux (
        .rd_addr    (rd_addr),
        .cnt_live   (tmr_cnt_live),
        .stage_flat (stage_flat),
        .busy_vec   (busy_vec),
        .rd_data    (rd_data)
    );

    assign wr_while_busy = async_sel && |(wr_hit & busy_vec);

    assign tmr_cnt_val  = tmr_flat[0*DW +: DW];
    assign tmr_cmp_a    = tmr_flat[1*DW +: DW];
    assign tmr_cmp_b    = tmr_flat[2*DW +: DW];
    assign tmr_ctl_a    = tmr_flat[3*DW +: DW];
    assign tmr_ctl_b    = tmr_flat[4*DW +: DW];
    assign tmr_cnt_load = upd_vec[0];

endmodule

// File: rtl/ats_checker.sv
// Assertion checker for async_timer_stage, attached by bind below.
module ats_checker #(
    parameter int DW = 8,
    parameter int NR = 5,
    parameter int AW = 3
) (
    input logic             sys_clk,
    input logic             sys_rst_n,
    input logic             tmr_clk,
    input logic             tmr_rst_n,
    input logic             async_sel,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [NR-1:0]    busy_vec,
    input logic [NR*DW-1:0] stage_flat,
    input logic [NR*DW-1:0] tmr_flat,
    input logic             tmr_cnt_load
);

    genvar gi;
    generate
        for (gi = 0; gi < NR; gi++) begin : g_chk
            // R2: an asynchronous write raises that register's busy bit next cycle
            p_busy_set_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
                async_sel && wr_en && wr_addr == AW'(gi) |=> busy_vec[gi]);

            // R5: staging copy holds while busy and not rewritten
            p_stage_hold_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
                busy_vec[gi] && !(wr_en && wr_addr == AW'(gi)) |=> $stable(stage_flat[gi*DW +: DW]));

            // R3: when busy drops, the timer copy matches the staging copy
            p_clear_match_r3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
                $fell(busy_vec[gi]) |-> tmr_flat[gi*DW +: DW] == stage_flat[gi*DW +: DW]);
        end
    endgenerate

    // R8: direct mode never raises a busy bit
    p_direct_idle_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !async_sel && $past(!async_sel) && $past(busy_vec) == '0 |-> busy_vec == '0);

    // R9: counter load pulse lasts one timer cycle in asynchronous mode
    p_load_pulse_r9: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        async_sel && tmr_cnt_load |=> !tmr_cnt_load);

endmodule

bind async_timer_stage ats_checker #(
    .DW (DW),
    .NR (ats_pkg::NREG),
    .AW (ats_pkg::ADDR_W)
) u_chk (
    .sys_clk      (sys_clk),
    .sys_rst_n    (sys_rst_n),
    .tmr_clk      (tmr_clk),
    .tmr_rst_n    (tmr_rst_n),
    .async_sel    (async_sel),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .busy_vec     (busy_vec),
    .stage_flat   (stage_flat),
    .tmr_flat     (tmr_flat),
    .tmr_cnt_load (tmr_cnt_load)
);

// File: tb/async_timer_stage_bench.sv
`timescale 1ns/1ps
module async_timer_stage_bench;

    logic       sys_clk = 1'b0;
    logic       aclk    = 1'b0;
    logic       use_same = 1'b0;
    logic       tmr_clk;
    logic       sys_rst_n = 1'b0;
    logic       tmr_rst_n = 1'b0;
    logic       async_sel = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_while_busy;
    logic [7:0] tmr_cnt_live = '0;
    logic [7:0] tmr_cnt_val, tmr_cmp_a, tmr_cmp_b, tmr_ctl_a, tmr_ctl_b;
    logic       tmr_cnt_load;

    int checks = 0;
    int errors = 0;
    int loads  = 0;
    int cyc    = 0;
    logic [7:0] expv [5];

    always #5 sys_clk = ~sys_clk;
    always #17.3 aclk = ~aclk;
    assign tmr_clk = use_same ? sys_clk : aclk;

    async_timer_stage u_async_timer_stage (
        .sys_clk       (sys_clk),
        .sys_rst_n     (sys_rst_n),
        .tmr_clk       (tmr_clk),
        .tmr_rst_n     (tmr_rst_n),
        .async_sel     (async_sel),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .wr_while_busy (wr_while_busy),
        .tmr_cnt_live  (tmr_cnt_live),
        .tmr_cnt_val   (tmr_cnt_val),
        .tmr_cnt_load  (tmr_cnt_load),
        .tmr_cmp_a     (tmr_cmp_a),
        .tmr_cmp_b     (tmr_cmp_b),
        .tmr_ctl_a     (tmr_ctl_a),
        .tmr_ctl_b     (tmr_ctl_b)
    );

    // Count counter-load pulses away from the timer edge.
    always @(negedge tmr_clk) if (tmr_cnt_load) loads++;

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge sys_clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            finish_up();
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] tval(input int i);
        case (i)
            0: return tmr_cnt_val;
            1: return tmr_cmp_a;
            2: return tmr_cmp_b;
            3: return tmr_ctl_a;
            default: return tmr_ctl_b;
        endcase
    endfunction

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // One write cycle; returns at the negedge after the write edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge sys_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        for (int k = 0; k < 200; k++) begin
            rd(3'd5, v);
            if (v == 8'h00) break;
            @(negedge sys_clk);
        end
        chk(tag, v, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
        int         lc;

        repeat (6) @(negedge aclk);
        sys_rst_n = 1'b1;
        tmr_rst_n = 1'b1;
        @(negedge sys_clk);

        // R10: reset state
        for (int a = 1; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R10 reset read addr %0d", a), v, 8'h00);
        end
        for (int i = 0; i < 5; i++) begin
            chk($sformatf("R10 reset timer copy %0d", i), tval(i), 8'h00);
            expv[i] = 8'h00;
        end

        // R6: counter address shows the live input
        for (int p = 0; p < 4; p++) begin
            tmr_cnt_live = 8'(p * 67 + 9);
            rd(3'd0, v);
            chk("R6 live counter readback", v, 8'(p * 67 + 9));
        end

        // Asynchronous sweep over every register and data pattern: R1 R2 R4 R5 R3 R9
        for (int i = 0; i < 5; i++) begin
            for (int p = 0; p < 5; p++) begin
                d  = pats[p] ^ 8'(i * 17);
                lc = loads;
                wr(3'(i), d);
                rd(3'd5, v);
                chk($sformatf("R1/R2 status after write reg %0d", i), v, 8'(1 << (4 - i)));
                chk($sformatf("R4 timer copy still old reg %0d", i), tval(i), expv[i]);
                if (i != 0) begin
                    rd(3'(i), v);
                    chk($sformatf("R5 staging readback reg %0d", i), v, d);
                end
                wait_idle($sformatf("R3 busy clears reg %0d", i));
                chk($sformatf("R3 timer copy reg %0d", i), tval(i), d);
                expv[i] = d;
                if (i == 0) begin
                    repeat (8) @(negedge sys_clk);
                    chk("R9 one load pulse per counter write", 8'(loads - lc), 8'd1);
                end
            end
        end

        // R11: writes to status and unused addresses are ignored
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hC3);
            rd(3'd5, v);
            chk($sformatf("R11 status after write addr %0d", a), v, 8'h00);
        end
        repeat (10) @(negedge sys_clk);
        for (int i = 0; i < 5; i++) begin
            chk($sformatf("R11 timer copy reg %0d unchanged", i), tval(i), expv[i]);
            if (i != 0) begin
                rd(3'(i), v);
                chk($sformatf("R11 staging reg %0d unchanged", i), v, expv[i]);
            end
        end

        // R7: second write swept across the full round trip
        for (int g = 0; g < 25; g++) begin
            logic exp_flag;
            logic got_flag;
            wr(3'd1, 8'(g));
            repeat (g) @(negedge sys_clk);
            @(negedge sys_clk);
            wr_en = 1'b1; wr_addr = 3'd1; wr_data = ~8'(g);
            rd(3'd5, v);
            exp_flag = v[3];
            got_flag = wr_while_busy;
            @(negedge sys_clk);
            wr_en = 1'b0;
            if (g == 0) chk("R7 flag on immediate rewrite", {7'd0, got_flag}, 8'd1);
            else        chk($sformatf("R7 flag matches busy gap %0d", g), {7'd0, got_flag}, {7'd0, exp_flag});
            wait_idle($sformatf("R7 idle gap %0d", g));
            chk($sformatf("R7 newest value gap %0d", g), tmr_cmp_a, ~8'(g));
        end
        expv[1] = ~8'(24);

        // R8: direct mode with a shared clock
        @(negedge sys_clk);
        async_sel = 1'b0;
        use_same  = 1'b1;
        repeat (3) @(negedge sys_clk);
        for (int i = 0; i < 5; i++) begin
            d  = 8'(8'h81 + i * 29);
            lc = loads;
            @(negedge sys_clk);
            wr_en = 1'b1; wr_addr = 3'(i); wr_data = d;
            #1;
            chk($sformatf("R8 no busy flag reg %0d", i), {7'd0, wr_while_busy}, 8'd0);
            @(negedge sys_clk);
            wr_en = 1'b0;
            chk($sformatf("R8 timer copy on write edge reg %0d", i), tval(i), d);
            rd(3'd5, v);
            chk($sformatf("R8 status stays zero reg %0d", i), v, 8'h00);
            if (i == 0) begin
                repeat (2) @(negedge sys_clk);
                chk("R9 direct counter load pulse", 8'(loads - lc), 8'd1);
            end
        end

        finish_up();
    end

endmodule